// File: doc/BRIEF.md
# Priority-Level Interrupt Arbiter

This block sits between a set of request-raising devices and a processor. Each device has its own request line and a 3-bit urgency level supplied by configuration inputs. Every cycle the arbiter finds the most urgent pending device and compares that device's level with the priority level of the program now running. It raises the single interrupt line to the processor only when the device's level is strictly higher.

The interrupt flag, the winning device index and the winning level are registered together. The processor therefore sees a consistent set one cycle after the inputs change. The processor looks at the flag only at its instruction boundary, after one instruction's store step and before the next fetch. When it takes the interrupt it pulses an accept strobe. The arbiter then reports, for one cycle, which device and level were accepted.

Top module: `irq_level_arbiter`

## Requirements
- R1: While reset is held, and on the first cycle after it, `irq_o`, `win_idx_o`, `win_lvl_o`, `taken_vld_o`, `taken_idx_o` and `taken_lvl_o` are all zero.
- R2: `irq_o` is 1 only when the winning level is strictly greater than `cur_lvl_i`. A winner whose level equals or is below the current level gives `irq_o` = 0.
- R3: Among the devices with `req_i[i]` = 1, the winner is one whose level is the highest. Level 7 is the most urgent and level 0 the least. Device i's level is `dev_lvl_i[3*i+2:3*i]`.
- R4: When several pending devices share the highest level, the one with the lowest index wins.
- R5: `irq_o`, `win_idx_o` and `win_lvl_o` reflect the inputs sampled at the previous rising clock edge, with exactly one cycle of latency.
- R6: With no request pending, `irq_o`, `win_idx_o` and `win_lvl_o` are all 0.
- R7: The level configured for a device whose request is low has no effect on the outputs.
- R8: When `take_i` is 1 in a cycle where `irq_o` is 1, then in the next cycle `taken_vld_o` is 1 and `taken_idx_o`/`taken_lvl_o` equal the `win_idx_o`/`win_lvl_o` shown when the strobe was sampled.
- R9: When `take_i` is 1 while `irq_o` is 0, `taken_vld_o` stays 0 and `taken_idx_o`/`taken_lvl_o` keep their values.
- R10: When a request is pending but not urgent enough to interrupt, `win_idx_o` and `win_lvl_o` still report the winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_i | input | 8 | Request line of each device |
| dev_lvl_i | input | 24 | Packed 3-bit level per device; device i at bits 3i+2:3i |
| cur_lvl_i | input | 3 | Priority level of the running program |
| take_i | input | 1 | One-cycle strobe from the processor accepting the interrupt |
| irq_o | output | 1 | Interrupt request to the processor |
| win_idx_o | output | 3 | Index of the winning device |
| win_lvl_o | output | 3 | Level of the winning device |
| taken_vld_o | output | 1 | Pulses one cycle after an accepted interrupt |
| taken_idx_o | output | 3 | Index of the accepted device |
| taken_lvl_o | output | 3 | Level of the accepted device |

## Verification
The hardest situation to reach is a tie at the top level while a less urgent device with a higher index is also pending, combined with a running level that sits exactly at the winner's level. The stimulus builds this case directly by loading chosen level vectors and a matching `cur_lvl_i`. It then lowers the running level by one step to show that the same winner now interrupts. The accept path is driven both while the interrupt is up and while it is down. The accepted record is read back on the following cycle in each case.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int DEF_NUM_DEV = 8;
  localparam int DEF_LVL_W   = 3;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/irq_level_select.sv
// Finds the most urgent pending device; lowest index wins a tie.
module irq_level_select #(
  parameter int NUM_DEV = 8,
  parameter int LVL_W   = 3,
  parameter int IDX_W   = $clog2(NUM_DEV)
) (
  input  logic [NUM_DEV-1:0]       req,
  input  logic [NUM_DEV*LVL_W-1:0] lvl_flat,
  output logic                     any,
  output logic [IDX_W-1:0]         best_idx,
  output logic [LVL_W-1:0]         best_lvl
);
  always_comb begin
    any      = 1'b0;
    best_idx = '0;
    best_lvl = '0;
    for (int i = 0; i < NUM_DEV; i++) begin
      if (req[i] && (!any || (lvl_flat[i*LVL_W +: LVL_W] > best_lvl))) begin
        any      = 1'b1;
        best_idx = IDX_W'(i);
        best_lvl = lvl_flat[i*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/irq_level_gate.sv
// Lets a winner through only when strictly above the running level.
module irq_level_gate #(
  parameter int LVL_W = 3
) (
  input  logic             any,
  input  logic [LVL_W-1:0] best_lvl,
  input  logic [LVL_W-1:0] cur_lvl,
  output logic             fire
);
  assign fire = any && (best_lvl > cur_lvl);
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter #(
  parameter int NUM_DEV = irq_arb_pkg::DEF_NUM_DEV,
  parameter int LVL_W   = irq_arb_pkg::DEF_LVL_W,
  localparam int IDX_W  = $clog2(NUM_DEV),
  localparam int CFG_W  = NUM_DEV * LVL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_DEV-1:0] req_i,
  input  logic [CFG_W-1:0]   dev_lvl_i,
  input  logic [LVL_W-1:0]   cur_lvl_i,
  input  logic               take_i,
  output logic               irq_o,
  output logic [IDX_W-1:0]   win_idx_o,
  output logic [LVL_W-1:0]   win_lvl_o,
  output logic               taken_vld_o,
  output logic [IDX_W-1:0]   taken_idx_o,
  output logic [LVL_W-1:0]   taken_lvl_o
);
  logic             rst_n_s;
  logic             sel_any;
  logic [IDX_W-1:0] sel_idx;
  logic [LVL_W-1:0] sel_lvl;
  logic             sel_fire;

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  irq_level_select #(.NUM_DEV(NUM_DEV), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_sel (
    .req      (req_i),
    .lvl_flat (dev_lvl_i),
    .any      (sel_any),
    .best_idx (sel_idx),
    .best_lvl (sel_lvl)
  );

  irq_level_gate #(.LVL_W(LVL_W)) u_gate (
    .any      (sel_any),
    .best_lvl (sel_lvl),
    .cur_lvl  (cur_lvl_i),
    .fire     (sel_fire)
  );

  // next-state
  logic             irq_d, tvld_d, tcap_en;
  logic [IDX_W-1:0] widx_d, tidx_d;
  logic [LVL_W-1:0] wlvl_d, tlvl_d;

  always_comb begin
    irq_d   = sel_fire;
    widx_d  = sel_idx;
    wlvl_d  = sel_lvl;
    tcap_en = take_i && irq_o;
    tvld_d  = tcap_en;
    tidx_d  = taken_idx_o;
    tlvl_d  = taken_lvl_o;
    if (tcap_en) begin
      tidx_d = win_idx_o;
      tlvl_d = win_lvl_o;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      irq_o       <= 1'b0;
      win_idx_o   <= '0;
      win_lvl_o   <= '0;
      taken_vld_o <= 1'b0;
      taken_idx_o <= '0;
      taken_lvl_o <= '0;
    end else begin
      irq_o       <= irq_d;
      win_idx_o   <= widx_d;
      win_lvl_o   <= wlvl_d;
      taken_vld_o <= tvld_d;
      if (tcap_en) begin
        taken_idx_o <= tidx_d;
        taken_lvl_o <= tlvl_d;
      end
    end
  end
endmodule

// File: rtl/irq_level_arbiter_chk.sv
module irq_level_arbiter_chk #(
  parameter int NUM_DEV = 8,
  parameter int LVL_W   = 3,
  parameter int IDX_W   = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_DEV-1:0]       req_i,
  input logic [NUM_DEV*LVL_W-1:0] dev_lvl_i,
  input logic [LVL_W-1:0]         cur_lvl_i,
  input logic                     irq_o,
  input logic [IDX_W-1:0]         win_idx_o,
  input logic [LVL_W-1:0]         win_lvl_o,
  input logic                     taken_vld_o,
  input logic [IDX_W-1:0]         taken_idx_o
);
  logic [NUM_DEV-1:0]       req_d;
  logic [NUM_DEV*LVL_W-1:0] lvl_d;
  logic [LVL_W-1:0]         cur_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_d <= '0;
      lvl_d <= '0;
      cur_d <= '0;
    end else begin
      req_d <= req_i;
      lvl_d <= dev_lvl_i;
      cur_d <= cur_lvl_i;
    end
  end

  // R2
  irq_above_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (win_lvl_o > cur_d));

  // R3
  irq_src_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> req_d[win_idx_o]);

  // R3
  irq_lvl_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (win_lvl_o == lvl_d[int'(win_idx_o)*LVL_W +: LVL_W]));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_d == '0) |-> !irq_o);

  // R8
  taken_after_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken_vld_o |-> $past(irq_o));

  // R8
  taken_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken_vld_o |-> (taken_idx_o == $past(win_idx_o)));
endmodule

bind irq_level_arbiter irq_level_arbiter_chk #(
  .NUM_DEV(NUM_DEV), .LVL_W(LVL_W), .IDX_W(IDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_i       (req_i),
  .dev_lvl_i   (dev_lvl_i),
  .cur_lvl_i   (cur_lvl_i),
  .irq_o       (irq_o),
  .win_idx_o   (win_idx_o),
  .win_lvl_o   (win_lvl_o),
  .taken_vld_o (taken_vld_o),
  .taken_idx_o (taken_idx_o)
);

// File: tb/tb_irq_level_arbiter.sv
module tb_irq_level_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  req = '0;
  logic [23:0] lvls = '0;
  logic [2:0]  cur = '0;
  logic        take = 1'b0;
  logic        irq, tvld;
  logic [2:0]  widx, wlvl, tidx, tlvl;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  irq_level_arbiter dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .dev_lvl_i(lvls), .cur_lvl_i(cur),
    .take_i(take), .irq_o(irq), .win_idx_o(widx), .win_lvl_o(wlvl),
    .taken_vld_o(tvld), .taken_idx_o(tidx), .taken_lvl_o(tlvl)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] pack(input int l0, l1, l2, l3, l4, l5, l6, l7);
    return {3'(l7), 3'(l6), 3'(l5), 3'(l4), 3'(l3), 3'(l2), 3'(l1), 3'(l0)};
  endfunction

  // apply inputs and check the registered result one edge later (R5)
  task automatic apply(input string tag, input logic [7:0] r, input logic [23:0] l,
                       input int c, input int e_irq, input int e_idx, input int e_lvl);
    @(negedge clk);
    req = r; lvls = l; cur = 3'(c);
    @(negedge clk);
    chk({tag, " irq"}, int'(irq), e_irq);
    chk({tag, " idx"}, int'(widx), e_idx);
    chk({tag, " lvl"}, int'(wlvl), e_lvl);
  endtask

  task automatic t_reset;
    chk("R1 irq", int'(irq), 0);
    chk("R1 idx", int'(widx), 0);
    chk("R1 lvl", int'(wlvl), 0);
    chk("R1 tvld", int'(tvld), 0);
    chk("R1 tidx", int'(tidx), 0);
    chk("R1 tlvl", int'(tlvl), 0);
  endtask

  task automatic t_levels;
    apply("R6 idle", 8'h00, pack(7,7,7,7,7,7,7,7), 0, 0, 0, 0);
    apply("R3 single6", 8'h04, pack(0,0,6,0,0,0,0,0), 0, 1, 2, 6);
    apply("R2 low_under_high", 8'h01, pack(0,0,0,0,0,0,0,0), 6, 0, 0, 0);
    apply("R3 highest", 8'hA5, pack(1,0,4,0,0,3,0,5), 2, 1, 7, 5);
    apply("R2 equal", 8'h10, pack(0,0,0,0,4,0,0,0), 4, 0, 4, 4);
    apply("R10 below", 8'h20, pack(0,0,0,0,0,2,0,0), 5, 0, 5, 2);
    apply("R2 above_by_one", 8'h10, pack(0,0,0,0,4,0,0,0), 3, 1, 4, 4);
  endtask

  task automatic t_tie;
    apply("R4 tie_at_cur", 8'hE8, pack(0,0,0,5,0,5,5,4), 5, 0, 3, 5);
    apply("R4 tie_fires", 8'hE8, pack(0,0,0,5,0,5,5,4), 4, 1, 3, 5);
    apply("R4 tie_zero", 8'hC0, pack(0,0,0,0,0,0,0,0), 0, 0, 6, 0);
  endtask

  task automatic t_ignore;
    apply("R7 masked_high", 8'h02, pack(7,1,7,7,7,7,7,7), 0, 1, 1, 1);
  endtask

  task automatic t_latency;
    @(negedge clk);
    req = 8'h80; lvls = pack(0,0,0,0,0,0,0,6); cur = 3'd0;
    chk("R5 not_yet", int'(irq), 1);
    chk("R5 old_idx", int'(widx), 1);
    @(negedge clk);
    chk("R5 after_edge", int'(irq), 1);
    chk("R5 after_idx", int'(widx), 7);
  endtask

  task automatic t_take;
    apply("R8 setup", 8'h40, pack(0,0,0,0,0,0,3,0), 1, 1, 6, 3);
    take = 1'b1;
    @(negedge clk);
    take = 1'b0;
    chk("R8 tvld", int'(tvld), 1);
    chk("R8 tidx", int'(tidx), 6);
    chk("R8 tlvl", int'(tlvl), 3);
    @(negedge clk);
    chk("R8 pulse_ends", int'(tvld), 0);
    apply("R9 setup", 8'h02, pack(0,2,0,0,0,0,0,0), 5, 0, 1, 2);
    take = 1'b1;
    @(negedge clk);
    take = 1'b0;
    chk("R9 tvld", int'(tvld), 0);
    chk("R9 tidx", int'(tidx), 6);
    chk("R9 tlvl", int'(tlvl), 3);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    repeat (3) @(negedge clk);
    t_levels();
    t_tie();
    t_ignore();
    t_latency();
    t_take();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule